// File: doc/BRIEF.md
# Asynchronous static RAM cycle controller

This block sits between a simple synchronous host port and an asynchronous byte-wide static RAM. It has a 19-bit address and active-low select, write strobe and output-enable pins. The data pins are shown as separate drive value, drive enable and sample value signals. The host raises a one-clock request with a direction bit, an address and write data. The controller then runs one complete bus cycle and answers with a one-clock acknowledge. A read returns its captured byte on the same clock as the acknowledge.

Every analog time limit of the memory is a nanosecond parameter, and the clock period is one more. At elaboration each limit is turned into a whole number of clocks, always rounded up. The controller also manages bus turnaround. After a read it keeps its own data drivers off until the memory has had time to release the bus. It also drops its drivers before any read turns the memory's outputs on.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high and on the clock after it, the select, write strobe and output enable pins are high, the data drivers are off and acknowledge is low.
- R2: A read holds select and output enable low and write strobe high for exactly RD_CYC clocks, with the data drivers off. RD_CYC is the largest of the cycle time, address access time and output-enable access time, each divided by the clock period and rounded up (14 with the defaults).
- R3: A read returns in rdata the value on the data input pins at the clock edge where select and output enable go back high. Acknowledge is high for the clock that follows that edge.
- R4: A write runs in three phases with output enable high. First, one setup clock with select low and write strobe high. Next, write strobe low for WP_CYC clocks, where WP_CYC is the larger of the write pulse and data-overlap times over the clock period, rounded up (11). Last, REC_CYC recovery clocks with select low and write strobe high (2). REC_CYC is the larger of the recovery time and the rest of the minimum write cycle time. Acknowledge follows the clock edge where select rises.
- R5: The address pins never change while select stays low. The data drive value never changes while the drivers stay on.
- R6: Write strobe is low only while select is low, and output enable is never low while write strobe is low.
- R7: The data drivers are never on while output enable is low. After output enable rises, the drivers stay off for at least HZ_CYC clocks, the bus release time over the clock period rounded up (5). A write requested right after a read waits for this interval.
- R8: A request raised while a cycle is in progress is ignored. It produces no acknowledge and leaves the memory contents unchanged.
- R9: Each accepted request yields exactly one acknowledge, one clock wide.
- R10: Cycle counts round up. With a clock period of 8 ns and the default times, a read holds output enable low for 9 clocks and a write holds write strobe low for 7 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-clock request strobe, taken only when idle |
| we | input | 1 | Request direction: 1 write, 0 read |
| addr | input | AW | Request address |
| wdata | input | DW | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DW | Read data, valid with ack after a read |
| sram_addr | output | AW | Memory address pins |
| sram_dq_out | output | DW | Value driven onto the data pins |
| sram_dq_oe | output | 1 | Data pin drive enable |
| sram_dq_in | input | DW | Value sampled from the data pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The bound checker checks on every clock the pin relations that must never break. These are drive contention against output enable, strobe only inside select, the stability of address and drive data, the exact widths of the output-enable and write-strobe pulses, the bus release gap and the single-clock acknowledge. Other behaviour shows only in the bench's scenarios. These are the value captured on a read against what earlier writes stored, the three-phase write layout, the wait of a write that directly follows a read, a request dropped while busy, and the rounding seen at a slower clock period.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WWAIT,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_guard.sv
module sram_bus_guard #(
  parameter int HOLD = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic clear
);

  localparam int GW = $clog2(HOLD + 2);
  localparam logic [GW-1:0] HOLD_V = GW'(HOLD);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start)
      cnt_q <= HOLD_V;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign clear = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 19,
  parameter int DW      = 8,
  parameter int CLK_NS  = 5,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 50,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_DW_NS = 30,
  parameter int T_WR_NS = 5,
  parameter int T_HZ_NS = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n
);

  // Clock counts derived from the nanosecond limits, rounded up.
  localparam int RD_CYC  = max2(1, max2(ceil_div(T_RC_NS, CLK_NS),
                                        max2(ceil_div(T_AA_NS, CLK_NS),
                                             ceil_div(T_OE_NS, CLK_NS))));
  localparam int WP_CYC  = max2(1, ceil_div(max2(T_WP_NS, T_DW_NS), CLK_NS));
  localparam int WC_CYC  = ceil_div(T_WC_NS, CLK_NS);
  localparam int REC_CYC = max2(1, max2(ceil_div(T_WR_NS, CLK_NS), WC_CYC - 1 - WP_CYC));
  localparam int HZ_CYC  = ceil_div(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = max2(RD_CYC, max2(WP_CYC, REC_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);

  ctrl_state_e   state_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          bus_free;
  logic          rd_end;

  // Timer load selection per phase entry.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req && !we) begin
        tmr_load = 1'b1;
        tmr_val  = RD_LD;
      end
      ST_WSETUP: begin
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
      end
      ST_WPULSE: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
      end
      default: ;
    endcase
  end

  assign rd_end = (state_q == ST_READ) && tmr_done;

  sram_phase_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_bus_guard #(.HOLD(HZ_CYC)) guard_i (
    .clk   (clk),
    .rst   (rst),
    .start (rd_end),
    .clear (bus_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sram_cs_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      rdata       <= '0;
      ack         <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req) begin
          sram_addr <= addr;
          if (!we) begin
            sram_cs_n <= 1'b0;
            sram_oe_n <= 1'b0;
            state_q   <= ST_READ;
          end else begin
            sram_dq_out <= wdata;
            if (bus_free) begin
              sram_cs_n  <= 1'b0;
              sram_dq_oe <= 1'b1;
              state_q    <= ST_WSETUP;
            end else begin
              state_q <= ST_WWAIT;
            end
          end
        end
        ST_READ: if (tmr_done) begin
          rdata     <= sram_dq_in;
          ack       <= 1'b1;
          sram_cs_n <= 1'b1;
          sram_oe_n <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_WWAIT: if (bus_free) begin
          sram_cs_n  <= 1'b0;
          sram_dq_oe <= 1'b1;
          state_q    <= ST_WSETUP;
        end
        ST_WSETUP: begin
          sram_we_n <= 1'b0;
          state_q   <= ST_WPULSE;
        end
        ST_WPULSE: if (tmr_done) begin
          sram_we_n <= 1'b1;
          state_q   <= ST_WRECOV;
        end
        ST_WRECOV: if (tmr_done) begin
          sram_cs_n  <= 1'b1;
          sram_dq_oe <= 1'b0;
          ack        <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 19,
  parameter int DW      = 8,
  parameter int CLK_NS  = 5,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 50,
  parameter int T_WP_NS = 55,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dq_out,
  input logic          sram_dq_oe,
  input logic          sram_cs_n,
  input logic          sram_we_n,
  input logic          sram_oe_n
);

  localparam int RD_CYC = max2(1, max2(ceil_div(T_RC_NS, CLK_NS),
                                       max2(ceil_div(T_AA_NS, CLK_NS),
                                            ceil_div(T_OE_NS, CLK_NS))));
  localparam int WP_CYC = max2(1, ceil_div(max2(T_WP_NS, T_DW_NS), CLK_NS));
  localparam int HZ_CYC = ceil_div(T_HZ_NS, CLK_NS);

  logic [15:0] oe_low_run;
  logic [15:0] we_low_run;
  logic [15:0] oe_high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_low_run  <= '0;
      we_low_run  <= '0;
      oe_high_run <= 16'hFFFF;
    end else begin
      oe_low_run  <= !sram_oe_n ? ((oe_low_run == 16'hFFFF) ? oe_low_run : oe_low_run + 1'b1) : '0;
      we_low_run  <= !sram_we_n ? ((we_low_run == 16'hFFFF) ? we_low_run : we_low_run + 1'b1) : '0;
      oe_high_run <= sram_oe_n ? ((oe_high_run == 16'hFFFF) ? oe_high_run : oe_high_run + 1'b1) : '0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !ack));

  p_read_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> (oe_low_run == 16'(RD_CYC)));

  p_we_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_low_run == 16'(WP_CYC)));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

  p_we_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_cs_n && sram_oe_n));

  p_no_fight_r7: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n));

  p_release_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (oe_high_run >= 16'(HZ_CYC)));

  p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_ack_after_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(!sram_cs_n));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
  .T_OE_NS(T_OE_NS), .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS), .T_HZ_NS(T_HZ_NS)
) chk_i (
  .clk(clk), .rst(rst), .ack(ack), .sram_addr(sram_addr),
  .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_cs_n(sram_cs_n),
  .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb_top;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int RD_EXP  = 14;
  localparam int WP_EXP  = 11;
  localparam int REC_EXP = 2;
  localparam int HZ_EXP  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack;
  logic [DW-1:0] rdata;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_out;
  logic          sram_dq_oe;
  logic [DW-1:0] sram_dq_in = 8'hEE;
  logic          sram_cs_n, sram_we_n, sram_oe_n;

  sram_cycle_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  // Second instance at an 8 ns period, for the rounding requirement.
  logic          d8_req = 1'b0, d8_we = 1'b0;
  logic          d8_ack;
  logic [DW-1:0] d8_rdata;
  logic [AW-1:0] d8_addr;
  logic [DW-1:0] d8_dq_out;
  logic          d8_dq_oe, d8_cs_n, d8_we_n, d8_oe_n;

  sram_cycle_ctrl #(.AW(AW), .DW(DW), .CLK_NS(8)) dut8_i (
    .clk(clk), .rst(rst), .req(d8_req), .we(d8_we), .addr('0), .wdata(8'h3C),
    .ack(d8_ack), .rdata(d8_rdata), .sram_addr(d8_addr), .sram_dq_out(d8_dq_out),
    .sram_dq_oe(d8_dq_oe), .sram_dq_in(8'h00), .sram_cs_n(d8_cs_n),
    .sram_we_n(d8_we_n), .sram_oe_n(d8_oe_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model and expected contents.
  logic [DW-1:0] model_mem [int];
  logic [DW-1:0] exp_mem [int];
  logic [DW-1:0] exp_q [$];
  bit cur_is_read = 1'b0;

  // Monitor state.
  int cs_run = 0, pre = 0, post = 0, last_cs = 0, last_pre = 0, last_post = 0;
  bit seen_we = 0;
  int we_run = 0, last_we = 0, oe_run = 0, last_oe = 0;
  int since_oe = 1000, last_gap = -1;
  bit prev_dq_oe = 0, prev_we_n = 1, prev_cs_low = 0, prev_ack = 0;
  logic [AW-1:0] prev_addr = '0;
  int viol_fight = 0, viol_wecs = 0, viol_addr = 0, viol_ack = 0;
  int ack_count = 0;
  int d8_oe_run = 0, d8_last_oe = 0, d8_we_run = 0, d8_last_we = 0;

  always @(negedge clk) begin
    if (!rst) begin
      // Memory model: store at the rising write strobe.
      if (!prev_we_n && sram_we_n && !sram_cs_n)
        model_mem[int'(sram_addr)] = sram_dq_out;
      if (!sram_cs_n && !sram_oe_n && sram_we_n)
        sram_dq_in <= model_mem.exists(int'(sram_addr)) ? model_mem[int'(sram_addr)] : 8'h00;
      else
        sram_dq_in <= 8'hEE;

      if (!sram_cs_n) begin
        cs_run++;
        if (!sram_we_n) seen_we = 1;
        else if (seen_we) post++;
        else pre++;
      end else if (cs_run != 0) begin
        last_cs = cs_run; last_pre = pre; last_post = post;
        cs_run = 0; pre = 0; post = 0; seen_we = 0;
      end
      if (!sram_we_n) we_run++;
      else if (we_run != 0) begin last_we = we_run; we_run = 0; end
      if (!sram_oe_n) oe_run++;
      else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end

      if (sram_dq_oe && !prev_dq_oe) last_gap = since_oe;
      since_oe = sram_oe_n ? since_oe + 1 : 0;

      if (sram_dq_oe && !sram_oe_n) viol_fight++;                  // R7
      if (!sram_we_n && (sram_cs_n || !sram_oe_n)) viol_wecs++;     // R6
      if (!sram_cs_n && prev_cs_low && sram_addr != prev_addr) viol_addr++; // R5
      if (ack && prev_ack) viol_ack++;                              // R9
      if (ack) ack_count++;

      // Scoreboard: compare read data as each acknowledge appears (R3).
      if (ack && cur_is_read) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected read ack", 0, 1);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rdata == e, "R3 read data", rdata, e);
        end
      end

      if (!d8_oe_n) d8_oe_run++;
      else if (d8_oe_run != 0) begin d8_last_oe = d8_oe_run; d8_oe_run = 0; end
      if (!d8_we_n) d8_we_run++;
      else if (d8_we_run != 0) begin d8_last_we = d8_we_run; d8_we_run = 0; end

      prev_dq_oe = sram_dq_oe; prev_we_n = sram_we_n; prev_cs_low = !sram_cs_n;
      prev_addr = sram_addr; prev_ack = ack;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ack(input string tag);
    int n = 0;
    while (!ack && n < 200) begin step(); n++; end
    if (n >= 200) check(1'b0, tag, 0, 1);
    step();
  endtask

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    step();
    req = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cur_is_read = 1'b0;
    exp_mem[int'(a)] = d;
    issue(1'b1, a, d);
    wait_ack("R9 write ack missing");
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    cur_is_read = 1'b1;
    exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00);
    issue(1'b0, a, '0);
    wait_ack("R9 read ack missing");
  endtask

  // Watchdog.
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1: idle levels while reset is held.
    check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !ack, "R1 reset pins",
          {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack}, 5'b11100);
    rst = 1'b0;
    step(); step();
    check(sram_cs_n && !sram_dq_oe && !ack, "R1 idle after reset",
          {sram_cs_n, sram_dq_oe, ack}, 3'b100);

    // R4: write phase layout.
    do_write(19'h00012, 8'hA7);
    check(last_pre == 1, "R4 setup clocks", last_pre, 1);
    check(last_we == WP_EXP, "R4 strobe clocks", last_we, WP_EXP);
    check(last_post == REC_EXP, "R4 recovery clocks", last_post, REC_EXP);
    check(last_cs == 1 + WP_EXP + REC_EXP, "R4 select clocks", last_cs, 1 + WP_EXP + REC_EXP);

    do_write(19'h7FFFF, 8'h5B);
    do_write(19'h40000, 8'h00);
    do_write(19'h00001, 8'hFF);

    // R2/R3: reads of several patterns.
    do_read(19'h00012);
    check(last_oe == RD_EXP, "R2 oe clocks", last_oe, RD_EXP);
    check(last_cs == RD_EXP, "R2 select clocks", last_cs, RD_EXP);
    do_read(19'h7FFFF);
    do_read(19'h40000);
    do_read(19'h00001);
    do_read(19'h12345);

    // R7: write immediately after a read waits for bus release.
    last_gap = -1;
    cur_is_read = 1'b1;
    exp_q.push_back(exp_mem[int'(19'h00012)]);
    issue(1'b0, 19'h00012, '0);
    wait_ack("R9 read ack missing");
    cur_is_read = 1'b0;
    exp_mem[int'(19'h00033)] = 8'hC3;
    issue(1'b1, 19'h00033, 8'hC3);
    wait_ack("R9 write ack missing");
    check(last_gap >= HZ_EXP, "R7 release gap", last_gap, HZ_EXP);
    do_read(19'h00033);

    // R8: a request while busy is dropped.
    begin
      int acks0;
      acks0 = ack_count;
      cur_is_read = 1'b0;
      exp_mem[int'(19'h00050)] = 8'h11;
      issue(1'b1, 19'h00050, 8'h11);
      repeat (3) step();
      issue(1'b1, 19'h00012, 8'h77);
      wait_ack("R9 write ack missing");
      repeat (20) step();
      check(ack_count - acks0 == 1, "R8 ack count", ack_count - acks0, 1);
    end
    do_read(19'h00012);
    do_read(19'h00050);

    // R10: rounding at 8 ns per clock.
    d8_req = 1'b1; d8_we = 1'b0; step(); d8_req = 1'b0;
    repeat (30) step();
    check(d8_last_oe == 9, "R10 read count", d8_last_oe, 9);
    d8_req = 1'b1; d8_we = 1'b1; step(); d8_req = 1'b0;
    repeat (30) step();
    check(d8_last_we == 7, "R10 strobe count", d8_last_we, 7);

    step();
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    check(viol_addr == 0, "R5 address moved under select", viol_addr, 0);
    check(viol_wecs == 0, "R6 strobe outside select", viol_wecs, 0);
    check(viol_fight == 0, "R7 drive during oe", viol_fight, 0);
    check(viol_ack == 0, "R9 wide ack", viol_ack, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule